// File: doc/BRIEF.md
# Serial Display-Data Receiver with Commit Latch

This block takes display frames from a three-wire serial link (a select line, a serial clock and a data line) and turns them into a bank of registered segment bits plus a duty-select flag for a segment display driver. All three link inputs are asynchronous to the core clock. They are brought into the core domain through two-flop synchronisers, and the serial clock is then edge-detected there. While the select line is high, each rising serial-clock edge shifts one data bit in, least significant bit first.

A frame is made of one or two 64-bit groups. Each group carries an 8-bit device address, 53 segment bits, two unused bits and a drive-type bit. When the select line falls, the block acts on the transfer. A single-group transfer with the right address rewrites the lower 53 segment bits and the drive-type flag. A two-group transfer whose groups both carry the right address rewrites all 106 segment bits and the flag. Every other transfer leaves the outputs exactly as they were. The outputs change only at that commit point, so they stay steady while a new frame is being shifted in.

Top module: `seg_frame_rx`

## Requirements
- R1: A synchronous active-low reset clears all 106 segment outputs and the duty flag to 0.
- R2: Within a group, bit i is the i-th bit sent. Bits 0..7 are the address, first bit least significant, and must equal 0xA2. Bits 8..60 are segment bits 1..53. Bits 61 and 62 are unused, and bit 63 is the drive-type bit. A transfer of exactly 64 bits loads `seg_out[52:0]` from bits 8..60 (bit 7+n lands on `seg_out[n-1]`) and `duty_half` from bit 63, and it leaves `seg_out[105:53]` unchanged.
- R3: A transfer of exactly 128 bits loads `seg_out[52:0]` from the first group. It loads `seg_out[105:53]` from bits 8..60 of the second group, and `duty_half` from bit 63 of the second group.
- R4: If any group of a transfer carries an address other than 0xA2, the whole transfer is ignored and no output changes.
- R5: A transfer whose length is neither 64 nor 128 bits is discarded and no output changes.
- R6: The outputs hold their values for the whole of a transfer and change only after the select line falls. The new values appear within 8 core-clock cycles of the fall.
- R7: A serial-clock rise that reaches the core in the same cycle as the select-line fall still counts as a shifted bit of that transfer.
- R8: The values of the two unused bits in each group have no effect on any output.
- R9: Serial-clock edges while the select line is low shift nothing and change no output. A later well-formed transfer is received correctly.
- R10: Correct reception needs only that each level of the serial clock and each select-line level last at least 3 core-clock cycles, with data steady across the rising serial-clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_sel | input | 1 | Serial select, high during a transfer (asynchronous) |
| ser_clk | input | 1 | Serial shift clock, data taken on rising edges (asynchronous) |
| ser_dat | input | 1 | Serial data, first bit least significant (asynchronous) |
| seg_out | output | 106 | Registered segment bits, 1 = segment on |
| duty_half | output | 1 | Registered drive-type flag, 1 = half duty, 0 = static |

## Verification
Two things can land in the same core cycle: the last serial-clock rise of a transfer and the fall of the select line. They meet when both arrive through the synchronisers together. The bench provokes this by raising the serial clock and dropping the select line at the same instant on the final bit of a 64-bit frame. It judges the result by whether the frame is committed as a full 64-bit transfer, which the reference model predicts. If that final edge were lost, the transfer would be 63 bits long, it would be discarded, and the outputs would show the mismatch.

// File: rtl/seg_frame_pkg.sv
// Package: shared constants for the serial display-data receiver.
// Assumes one group layout is used for both groups of a two-group transfer.
package seg_frame_pkg;
    localparam int GROUP_BITS = 64;
    localparam int ADDR_BITS  = 8;
    localparam int SEG_BITS   = 53;
    localparam logic [7:0] DEV_ADDR = 8'hA2;
endpackage

// File: rtl/seg_sync2.sv
// Module: seg_sync2
// Two-flop synchroniser for a vector of independent asynchronous bits.
// Assumes each bit is a level signal held for several core cycles.
module seg_sync2 #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            logic meta_q;
            logic safe_q;
            // Two-stage capture of one asynchronous bit
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    safe_q <= 1'b0;
                end else begin
                    meta_q <= d_async[gi];
                    safe_q <= meta_q;
                end
            end
            assign q_sync[gi] = safe_q;
        end
    endgenerate
endmodule

// File: rtl/seg_shift_front.sv
// Module: seg_shift_front
// Edge detection on the synchronised link, bit counting and the shift register.
// Shifting is qualified by the previous select level, so a serial-clock rise
// that arrives with the select fall still counts. The commit request is issued
// one cycle after the fall, once that last shift has landed.
module seg_shift_front #(
    parameter int GROUP_W = 64,
    parameter int CNT_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_s,
    input  logic                 sclk_s,
    input  logic                 sdat_s,
    output logic [2*GROUP_W-1:0] shreg,
    output logic [CNT_W-1:0]     bit_cnt,
    output logic                 commit_req,
    output logic                 sel_prev
);
    localparam int FULL_W = 2 * GROUP_W;
    localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(FULL_W + 1);

    logic sclk_prev;
    logic sel_rise, sel_fall, shift_en;

    assign sel_rise = sel_s & ~sel_prev;
    assign sel_fall = ~sel_s & sel_prev;
    assign shift_en = sclk_s & ~sclk_prev & sel_prev;

    // Remember previous synchronised levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_prev  <= 1'b0;
            sclk_prev <= 1'b0;
        end else begin
            sel_prev  <= sel_s;
            sclk_prev <= sclk_s;
        end
    end

    // Count shifted bits, saturating one past the longest legal length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
        end else if (sel_rise) begin
            bit_cnt <= '0;
        end else if (shift_en && bit_cnt != CNT_CAP) begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Shift right so the newest bit enters at the top
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (shift_en) begin
            shreg <= {sdat_s, shreg[FULL_W-1:1]};
        end
    end

    // Delay the select fall by one cycle to form the commit request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_req <= 1'b0;
        end else begin
            commit_req <= sel_fall;
        end
    end
endmodule

// File: rtl/seg_bank_latch.sv
// Module: seg_bank_latch
// Decodes the shift register on a commit request and updates the display bank.
// Assumes that after n shifts bit i of the transfer sits at shreg[FULL_W-n+i].
module seg_bank_latch #(
    parameter int GROUP_W = 64,
    parameter int ADDR_W  = 8,
    parameter int SEG_W   = 53,
    parameter int CNT_W   = 8,
    parameter logic [ADDR_W-1:0] ADDR_VAL = 8'hA2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2*GROUP_W-1:0] shreg,
    input  logic [CNT_W-1:0]     bit_cnt,
    input  logic                 commit_req,
    output logic [2*SEG_W-1:0]   seg_q,
    output logic                 duty_q
);
    localparam int DATA_LO = ADDR_W;
    localparam int DATA_HI = ADDR_W + SEG_W - 1;
    localparam int DP_POS  = GROUP_W - 1;
    localparam logic [CNT_W-1:0] LEN_ONE = CNT_W'(GROUP_W);
    localparam logic [CNT_W-1:0] LEN_TWO = CNT_W'(2 * GROUP_W);

    logic [GROUP_W-1:0] grp_first, grp_last;
    logic ok_first, ok_last;
    logic unused_dc;

    assign grp_first = shreg[GROUP_W-1:0];
    assign grp_last  = shreg[2*GROUP_W-1:GROUP_W];
    assign ok_first  = (grp_first[ADDR_W-1:0] == ADDR_VAL);
    assign ok_last   = (grp_last[ADDR_W-1:0] == ADDR_VAL);
    assign unused_dc = ^{grp_first[DP_POS-1:DATA_HI+1], grp_last[DP_POS-1:DATA_HI+1]};

    // Commit a well-formed transfer into the display bank
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q  <= '0;
            duty_q <= 1'b0;
        end else if (commit_req) begin
            if (bit_cnt == LEN_ONE && ok_last) begin
                seg_q[SEG_W-1:0] <= grp_last[DATA_HI:DATA_LO];
                duty_q           <= grp_last[DP_POS];
            end else if (bit_cnt == LEN_TWO && ok_first && ok_last) begin
                seg_q[SEG_W-1:0]       <= grp_first[DATA_HI:DATA_LO];
                seg_q[2*SEG_W-1:SEG_W] <= grp_last[DATA_HI:DATA_LO];
                duty_q                 <= grp_last[DP_POS];
            end
        end
    end
endmodule

// File: rtl/seg_frame_rx.sv
// Module: seg_frame_rx (top)
// Serial display-data receiver: synchronises the three link inputs, shifts in
// one or two 64-bit groups and commits them to registered outputs on select fall.
// Assumes the link levels last at least three core cycles each.
module seg_frame_rx #(
    parameter int GROUP_W = seg_frame_pkg::GROUP_BITS,
    parameter int ADDR_W  = seg_frame_pkg::ADDR_BITS,
    parameter int SEG_W   = seg_frame_pkg::SEG_BITS,
    parameter logic [ADDR_W-1:0] ADDR_VAL = seg_frame_pkg::DEV_ADDR
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_sel,
    input  logic               ser_clk,
    input  logic               ser_dat,
    output logic [2*SEG_W-1:0] seg_out,
    output logic               duty_half
);
    localparam int CNT_W = $clog2(2 * GROUP_W + 2);

    logic [2:0]           w_sync;
    logic [2*GROUP_W-1:0] w_sr;
    logic [CNT_W-1:0]     w_cnt;
    logic                 w_commit;
    logic                 w_sel_prev;

    seg_sync2 #(.WIDTH(3)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({ser_dat, ser_clk, ser_sel}),
        .q_sync  (w_sync)
    );

    seg_shift_front #(.GROUP_W(GROUP_W), .CNT_W(CNT_W)) u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_s      (w_sync[0]),
        .sclk_s     (w_sync[1]),
        .sdat_s     (w_sync[2]),
        .shreg      (w_sr),
        .bit_cnt    (w_cnt),
        .commit_req (w_commit),
        .sel_prev   (w_sel_prev)
    );

    seg_bank_latch #(
        .GROUP_W (GROUP_W),
        .ADDR_W  (ADDR_W),
        .SEG_W   (SEG_W),
        .CNT_W   (CNT_W),
        .ADDR_VAL(ADDR_VAL)
    ) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .shreg      (w_sr),
        .bit_cnt    (w_cnt),
        .commit_req (w_commit),
        .seg_q      (seg_out),
        .duty_q     (duty_half)
    );
endmodule

// File: rtl/seg_frame_rx_chk.sv
// Module: seg_frame_rx_chk
// Assertion checker bound to seg_frame_rx; observes ports and internal nets.
module seg_frame_rx_chk #(
    parameter int GROUP_W = 64,
    parameter int SEG_W   = 53,
    parameter int CNT_W   = 8,
    parameter logic [7:0] ADDR_VAL = 8'hA2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2*SEG_W-1:0]   seg_out,
    input logic                 duty_half,
    input logic [2*GROUP_W-1:0] sr,
    input logic [CNT_W-1:0]     cnt,
    input logic                 commit,
    input logic                 sel_prev,
    input logic                 sel_now
);
    logic rst_q;
    logic init_q;

    // Track reset history for the immediate reset check
    always_ff @(posedge clk) begin
        rst_q  <= rst_n;
        init_q <= 1'b1;
        if (init_q === 1'b1 && rst_q === 1'b0) begin
            p_reset_clear_r1: assert (seg_out == '0 && duty_half == 1'b0);
        end
    end

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(seg_out) && $stable(duty_half)));

    p_upper_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && cnt == CNT_W'(GROUP_W)) |=> $stable(seg_out[2*SEG_W-1:SEG_W]));

    p_bad_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && sr[GROUP_W+7:GROUP_W] != ADDR_VAL) |=> ($stable(seg_out) && $stable(duty_half)));

    p_bad_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && cnt != CNT_W'(GROUP_W) && cnt != CNT_W'(2*GROUP_W))
        |=> ($stable(seg_out) && $stable(duty_half)));

    p_cnt_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(2*GROUP_W + 1));

    p_idle_noshift_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_prev && !sel_now) |=> ($stable(cnt) && $stable(sr)));
endmodule

bind seg_frame_rx seg_frame_rx_chk #(
    .GROUP_W (GROUP_W),
    .SEG_W   (SEG_W),
    .CNT_W   (CNT_W),
    .ADDR_VAL(ADDR_VAL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .seg_out   (seg_out),
    .duty_half (duty_half),
    .sr        (w_sr),
    .cnt       (w_cnt),
    .commit    (w_commit),
    .sel_prev  (w_sel_prev),
    .sel_now   (w_sync[0])
);

// File: tb/seg_frame_rx_bench.sv
module seg_frame_rx_bench;
    localparam int HALF = 4;
    localparam int WDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_sel = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_dat = 1'b0;
    logic [105:0] seg_out;
    logic         duty_half;

    logic [105:0] exp_seg = '0;
    logic         exp_duty = 1'b0;
    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    seg_frame_rx u_seg_frame_rx (
        .clk(clk), .rst_n(rst_n), .ser_sel(ser_sel), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .seg_out(seg_out), .duty_half(duty_half)
    );

    function automatic logic [63:0] mk_group(input logic [7:0] a, input logic [52:0] d,
                                             input logic [1:0] dc, input logic dp);
        return {dp, dc, d, a};
    endfunction

    // Reference model of the commit rules (R2, R3, R4, R5)
    function automatic void model(input logic [127:0] b, input int len);
        if (len == 64 && b[7:0] == 8'hA2) begin
            exp_seg[52:0] = b[60:8];
            exp_duty      = b[63];
        end else if (len == 128 && b[7:0] == 8'hA2 && b[71:64] == 8'hA2) begin
            exp_seg[52:0]   = b[60:8];
            exp_seg[105:53] = b[124:72];
            exp_duty        = b[127];
        end
    endfunction

    task automatic cyc_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_out(input string tag);
        n_chk++;
        if (seg_out !== exp_seg || duty_half !== exp_duty) begin
            n_fail++;
            $display("FAIL %s: seg=%h duty=%b expected seg=%h duty=%b",
                     tag, seg_out, duty_half, exp_seg, exp_duty);
        end
    endtask

    // Shift a transfer; optional mid-transfer hold check and coincident last edge
    task automatic send(input logic [127:0] b, input int len, input bit coincide, input bit mid);
        ser_sel = 1'b1;
        cyc_wait(2 * HALF);
        for (int i = 0; i < len; i++) begin
            if (mid && i == 64) begin
                cyc_wait(4);
                check_out("R6 mid-transfer hold");
            end
            ser_dat = b[i % 128];
            ser_clk = 1'b0;
            cyc_wait(HALF);
            ser_clk = 1'b1;
            if (coincide && i == len - 1) ser_sel = 1'b0;
            cyc_wait(HALF);
        end
        ser_clk = 1'b0;
        cyc_wait(HALF);
        ser_sel = 1'b0;
        cyc_wait(10);
    endtask

    task automatic xfer(input logic [127:0] b, input int len, input bit coincide, input string tag);
        send(b, len, coincide, 1'b0);
        model(b, len);
        check_out(tag);
    endtask

    function automatic logic [52:0] rnd53();
        return {$urandom, $urandom};
    endfunction

    // Watchdog: counts an expiry as a failed check
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG && !done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cyc, WDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [127:0] b;
        logic [63:0] g0, g1;
        void'($urandom(32'd20240611));
        cyc_wait(5);
        rst_n = 1'b1;
        cyc_wait(2);
        check_out("R1 reset state");

        // R3 two-group transfer, with R6 hold check mid-way
        g0 = mk_group(8'hA2, rnd53(), 2'b01, 1'b0);
        g1 = mk_group(8'hA2, rnd53(), 2'b10, 1'b1);
        b = {g1, g0};
        send(b, 128, 1'b0, 1'b1);
        model(b, 128);
        check_out("R3 two-group load");

        // R2 single group keeps upper half
        b = {64'h0, mk_group(8'hA2, rnd53(), 2'b11, 1'b0)};
        xfer(b, 64, 1'b0, "R2 single group");

        // R4 wrong address, single and second group
        b = {64'h0, mk_group(8'hA3, rnd53(), 2'b00, 1'b1)};
        xfer(b, 64, 1'b0, "R4 bad address single");
        b = {mk_group(8'h45, rnd53(), 2'b00, 1'b0), mk_group(8'hA2, rnd53(), 2'b00, 1'b1)};
        xfer(b, 128, 1'b0, "R4 bad address second group");

        // R5 wrong lengths
        b = {mk_group(8'hA2, rnd53(), 2'b00, 1'b1), mk_group(8'hA2, rnd53(), 2'b00, 1'b1)};
        xfer(b, 63, 1'b0, "R5 length 63");
        xfer(b, 65, 1'b0, "R5 length 65");
        xfer(b, 127, 1'b0, "R5 length 127");
        xfer(b, 135, 1'b0, "R5 length 135");

        // R7 last edge coincides with select fall
        b = {64'h0, mk_group(8'hA2, rnd53(), 2'b00, 1'b1)};
        xfer(b, 64, 1'b1, "R7 coincident last edge");

        // R8 unused bits differ, same outcome
        g0 = mk_group(8'hA2, rnd53(), 2'b00, 1'b0);
        xfer({64'h0, g0}, 64, 1'b0, "R8 unused bits 00");
        g0[62:61] = 2'b11;
        xfer({64'h0, g0}, 64, 1'b0, "R8 unused bits 11");

        // R9 stray clocks while select low
        ser_dat = 1'b1;
        for (int k = 0; k < 20; k++) begin
            ser_clk = 1'b1; cyc_wait(HALF);
            ser_clk = 1'b0; cyc_wait(HALF);
        end
        cyc_wait(6);
        check_out("R9 idle edges ignored");
        b = {64'h0, mk_group(8'hA2, rnd53(), 2'b01, 1'b1)};
        xfer(b, 64, 1'b0, "R9 frame after idle edges");

        // Constrained random mix (R2 R3 R4 R5 R10)
        for (int t = 0; t < 24; t++) begin
            int kind;
            int len;
            kind = int'($urandom % 4);
            g0 = mk_group(8'hA2, rnd53(), 2'($urandom), 1'($urandom));
            g1 = mk_group(8'hA2, rnd53(), 2'($urandom), 1'($urandom));
            len = (kind == 1) ? 128 : 64;
            if (kind == 2) begin
                if ($urandom % 2 == 0) g0[7:0] = 8'($urandom) ^ 8'h01;
                else g1[7:0] = 8'h22;
                len = ($urandom % 2 == 0) ? 64 : 128;
                if (len == 64) b = {64'h0, g1}; else b = {g1, g0};
            end else if (kind == 3) begin
                len = 1 + int'($urandom % 140);
                if (len == 64 || len == 128) len = len + 1;
                b = {g1, g0};
            end else if (len == 64) begin
                b = {64'h0, g0};
            end else begin
                b = {g1, g0};
            end
            xfer(b, len, 1'b0, "R10 random transfer");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule